// File: doc/BRIEF.md
# Spike-Timing Synaptic Update Controller

This block controls the plasticity of a single synapse. It watches two spike inputs, one from the neuron that drives the synapse (pre) and one from the neuron it feeds (post), and applies a one-sided timing rule. A pre spike opens a timing window that is measured in timebase ticks. A post spike that lands while the window is open potentiates the synapse. A post spike that lands with no window open depresses the synapse, whether it came before any pre spike or after the window ran out.

When the block decides on an update, it latches either a potentiation enable or a depression enable and drives a signed polarity output. A potentiation pulse lasts three base units and a depression pulse lasts one. While either enable is up, the synapse's spike pass-through is cut and further spikes are ignored.

If a pulse runs its full length, the block emits a one-cycle increment or decrement strobe into an internal saturating weight register. An abort input ends a running pulse early, with no strobe. The tick period, window length, base unit, set-to-reset ratio and weight width are all parameters. At the defaults, with a 1 µs tick, the window is 2 ms and the base unit is 1 ms.

Top module: `syn_update_ctrl`

## Requirements
- R1: During and right after reset, both enables and both strobes are low, the polarity is 2'b00, the pass-through enable is high and the weight equals WEIGHT_INIT.
- R2: A post event seen 1 to WIN_TICKS tick cycles after a pre event (ticking every cycle) raises the potentiation enable after that edge, with polarity 2'b01 (positive).
- R3: A post event with no open window raises the depression enable after that edge, with polarity 2'b11 (negative). This covers a post with no earlier pre, a post before the pre, and a post WIN_TICKS+1 or more tick cycles after the pre.
- R4: A pre event that arrives while a window is open restarts the window at its full length.
- R5: The two enables are never high together, and pre or post events that arrive while an update runs are ignored. They neither start a second update nor open a window.
- R6: A potentiation pulse stays high for SET_MULT*UNIT_TICKS tick cycles and a depression pulse for UNIT_TICKS tick cycles.
- R7: The pass-through enable is low in exactly the cycles where either update enable is high.
- R8: At the edge where a full-length pulse ends, a one-cycle increment strobe (potentiation) or decrement strobe (depression) is raised. The weight moves by one on the next edge and saturates at 0 and at 2**WEIGHT_W-1.
- R9: An abort input seen during an update ends it at that edge with no strobe, and the weight stays unchanged.
- R10: The window and the pulse timers advance only on cycles with the tick input high. With no ticks, an open window stays open.
- R11: With EDGE_DETECT set, a spike input held high for many cycles counts as a single event at its rising edge.
- R12: A potentiation uses up its window, so a later post with no new pre causes depression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick, one cycle per time step |
| pre_spk_i | input | 1 | Pre-synaptic spike |
| post_spk_i | input | 1 | Post-synaptic spike |
| upd_abort_i | input | 1 | Ends a running update without a strobe |
| ltp_en_o | output | 1 | Potentiation pulse enable |
| ltd_en_o | output | 1 | Depression pulse enable |
| drive_pol_o | output | 2 | Pulse polarity: 01 positive, 11 negative, 00 idle |
| wt_inc_o | output | 1 | One-cycle increment strobe |
| wt_dec_o | output | 1 | One-cycle decrement strobe |
| weight_o | output | WEIGHT_W | Saturating synaptic weight |
| path_en_o | output | 1 | Spike pass-through enable |

## Verification
The bench places post spikes exactly WIN_TICKS and WIN_TICKS+1 ticks after a pre spike. An off-by-one in the window would flip one of these two from potentiation to depression. It restarts a window with a second pre, and it holds the tick low across a long gap. A design that failed to restart the window, or that counted clocks instead of ticks, would depress where potentiation is expected. It fires spikes into a running update, holds a pre input high for longer than the window, and sends a post after a consumed window. Missing gating, missing edge detection or a window that is not cleared each show up as an extra or wrong-kind pulse in the scoreboard. It also drives the weight into both rails and aborts a pulse, so a wrapping counter or a strobe on abort gives a wrong weight.

// File: rtl/syn_upd_pkg.sv
package syn_upd_pkg;

   // Update controller state; encoding is internal only.
   typedef enum logic [1:0] {
      UPD_IDLE = 2'd0,
      UPD_POT  = 2'd1,
      UPD_DEP  = 2'd2
   } upd_state_e;

   // Polarity codes on drive_pol_o.
   localparam logic [1:0] POL_NONE = 2'b00;
   localparam logic [1:0] POL_POS  = 2'b01;
   localparam logic [1:0] POL_NEG  = 2'b11;

endpackage

// File: rtl/stdp_window.sv
module stdp_window #(
   parameter int unsigned WIN_TICKS = 2000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic open_i,
   input  logic consume_i,
   output logic open_o
);

   localparam int unsigned CW = $clog2(WIN_TICKS + 1);
   localparam logic [CW-1:0] WIN_LD = CW'(WIN_TICKS);

   logic [CW-1:0] left_q;

   // Remaining ticks of the potentiation window; a fresh pre event wins.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (open_i) begin
         left_q <= WIN_LD;
      end else if (consume_i) begin
         left_q <= '0;
      end else if (tick_i && (left_q != '0)) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign open_o = (left_q != '0);

   // R4: the count never exceeds the window length
   p_win_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      left_q <= WIN_LD);

   // R4: a pre event leaves the window open on the next cycle
   p_win_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      open_i |=> open_o);

   // R10: without a tick or event the window does not move
   p_win_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !open_i && !consume_i) |=> $stable(left_q));

   // R12: a consumed window is closed on the next cycle
   p_win_consume_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (consume_i && !open_i) |=> !open_o);

endmodule

// File: rtl/stdp_pulse_gen.sv
module stdp_pulse_gen
   import syn_upd_pkg::*;
#(
   parameter int unsigned UNIT_TICKS = 1000,
   parameter int unsigned SET_MULT   = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic start_pot_i,
   input  logic start_dep_i,
   input  logic abort_i,
   output logic pot_o,
   output logic dep_o,
   output logic inc_o,
   output logic dec_o
);

   localparam int unsigned SET_T = SET_MULT * UNIT_TICKS;
   localparam int unsigned RST_T = UNIT_TICKS;
   localparam int unsigned DW    = $clog2(SET_T + 1);
   localparam logic [DW-1:0] SET_LD = DW'(SET_T);
   localparam logic [DW-1:0] RST_LD = DW'(RST_T);
   localparam logic [DW-1:0] LAST   = DW'(1);

   upd_state_e    st_q;
   logic [DW-1:0] dur_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= UPD_IDLE;
         dur_q <= '0;
         inc_o <= 1'b0;
         dec_o <= 1'b0;
      end else begin
         inc_o <= 1'b0;
         dec_o <= 1'b0;
         unique case (st_q)
            UPD_IDLE: begin
               if (start_pot_i) begin
                  st_q  <= UPD_POT;
                  dur_q <= SET_LD;
               end else if (start_dep_i) begin
                  st_q  <= UPD_DEP;
                  dur_q <= RST_LD;
               end
            end
            UPD_POT, UPD_DEP: begin
               if (abort_i) begin
                  st_q  <= UPD_IDLE;
                  dur_q <= '0;
               end else if (tick_i) begin
                  if (dur_q == LAST) begin
                     st_q  <= UPD_IDLE;
                     dur_q <= '0;
                     inc_o <= (st_q == UPD_POT);
                     dec_o <= (st_q == UPD_DEP);
                  end else begin
                     dur_q <= dur_q - 1'b1;
                  end
               end
            end
            default: begin
               st_q  <= UPD_IDLE;
               dur_q <= '0;
            end
         endcase
      end
   end

   assign pot_o = (st_q == UPD_POT);
   assign dep_o = (st_q == UPD_DEP);

   // R8: strobes last one cycle
   p_stb_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_o || dec_o) |=> !(inc_o || dec_o));

   // R8: an increment follows a potentiation pulse only
   p_inc_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_o |-> $past(pot_o));

   // R9: abort ends the pulse silently
   p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q != UPD_IDLE) && abort_i) |=> ((st_q == UPD_IDLE) && !inc_o && !dec_o));

   // R6: without a tick the pulse timer holds
   p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q != UPD_IDLE) && !tick_i && !abort_i) |=> ($stable(st_q) && $stable(dur_q)));

endmodule

// File: rtl/syn_weight_sat.sv
module syn_weight_sat #(
   parameter int unsigned WEIGHT_W    = 8,
   parameter int unsigned WEIGHT_INIT = 128
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                inc_i,
   input  logic                dec_i,
   output logic [WEIGHT_W-1:0] weight_o
);

   localparam logic [WEIGHT_W-1:0] W_MAX  = {WEIGHT_W{1'b1}};
   localparam logic [WEIGHT_W-1:0] W_INIT = WEIGHT_W'(WEIGHT_INIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         weight_o <= W_INIT;
      end else if (inc_i && !dec_i && (weight_o != W_MAX)) begin
         weight_o <= weight_o + 1'b1;
      end else if (dec_i && !inc_i && (weight_o != '0)) begin
         weight_o <= weight_o - 1'b1;
      end
   end

   // R8: saturation at the upper rail
   p_sat_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !dec_i && (weight_o == W_MAX)) |=> (weight_o == W_MAX));

   // R8: saturation at the lower rail
   p_sat_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && !inc_i && (weight_o == '0)) |=> (weight_o == '0));

   // R8: the weight moves only on a strobe
   p_still_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !dec_i) |=> $stable(weight_o));

endmodule

// File: rtl/syn_update_ctrl.sv
module syn_update_ctrl
   import syn_upd_pkg::*;
#(
   parameter int unsigned WIN_TICKS   = 2000,
   parameter int unsigned UNIT_TICKS  = 1000,
   parameter int unsigned SET_MULT    = 3,
   parameter int unsigned WEIGHT_W    = 8,
   parameter int unsigned WEIGHT_INIT = 128,
   parameter bit          EDGE_DETECT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                pre_spk_i,
   input  logic                post_spk_i,
   input  logic                upd_abort_i,
   output logic                ltp_en_o,
   output logic                ltd_en_o,
   output logic [1:0]          drive_pol_o,
   output logic                wt_inc_o,
   output logic                wt_dec_o,
   output logic [WEIGHT_W-1:0] weight_o,
   output logic                path_en_o
);

   localparam int unsigned N_SPK = 2;

   // Elaboration-time parameter checks
   if (WIN_TICKS < 1) begin : g_bad_win
      $error("WIN_TICKS must be at least 1");
   end
   if (UNIT_TICKS < 1) begin : g_bad_unit
      $error("UNIT_TICKS must be at least 1");
   end
   if (SET_MULT < 1) begin : g_bad_mult
      $error("SET_MULT must be at least 1");
   end
   if ((WEIGHT_W < 1) || (WEIGHT_W > 31)) begin : g_bad_ww
      $error("WEIGHT_W out of range");
   end else if (WEIGHT_INIT >= (1 << WEIGHT_W)) begin : g_bad_init
      $error("WEIGHT_INIT does not fit WEIGHT_W");
   end

   logic [N_SPK-1:0] spk_raw;
   logic [N_SPK-1:0] spk_evt;
   assign spk_raw = {post_spk_i, pre_spk_i};

   // Spike conditioning: rising-edge events or raw pulses
   for (genvar gi = 0; gi < N_SPK; gi++) begin : g_spk
      if (EDGE_DETECT) begin : g_edge
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= spk_raw[gi];
         end
         assign spk_evt[gi] = spk_raw[gi] & ~lvl_q;
      end else begin : g_level
         assign spk_evt[gi] = spk_raw[gi];
      end
   end

   logic busy, pre_acc, post_acc, win_open, start_pot, start_dep;

   assign busy      = ltp_en_o | ltd_en_o;
   assign pre_acc   = spk_evt[0] & ~busy;
   assign post_acc  = spk_evt[1] & ~busy;
   assign start_pot = post_acc & win_open;
   assign start_dep = post_acc & ~win_open;

   stdp_window #(
      .WIN_TICKS (WIN_TICKS)
   ) u_window (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick_i),
      .open_i    (pre_acc),
      .consume_i (start_pot),
      .open_o    (win_open)
   );

   stdp_pulse_gen #(
      .UNIT_TICKS (UNIT_TICKS),
      .SET_MULT   (SET_MULT)
   ) u_pulse (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick_i),
      .start_pot_i (start_pot),
      .start_dep_i (start_dep),
      .abort_i     (upd_abort_i),
      .pot_o       (ltp_en_o),
      .dep_o       (ltd_en_o),
      .inc_o       (wt_inc_o),
      .dec_o       (wt_dec_o)
   );

   syn_weight_sat #(
      .WEIGHT_W    (WEIGHT_W),
      .WEIGHT_INIT (WEIGHT_INIT)
   ) u_weight (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .inc_i    (wt_inc_o),
      .dec_i    (wt_dec_o),
      .weight_o (weight_o)
   );

   always_comb begin
      if (ltp_en_o)      drive_pol_o = POL_POS;
      else if (ltd_en_o) drive_pol_o = POL_NEG;
      else               drive_pol_o = POL_NONE;
   end

   assign path_en_o = ~busy;

   // R2: positive polarity during potentiation
   p_pol_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ltp_en_o |-> (drive_pol_o == POL_POS && !path_en_o));

   // R3: negative polarity during depression
   p_pol_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ltd_en_o |-> (drive_pol_o == POL_NEG && !path_en_o));

   // R5: a depression can never turn straight into a potentiation
   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ltd_en_o |=> !ltp_en_o);

   // R5: a post spike during an update starts nothing new
   p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ltp_en_o && spk_evt[1]) |=> !ltd_en_o);

   // R7: the path is open whenever no update runs
   p_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ltp_en_o && !ltd_en_o) |-> (path_en_o && drive_pol_o == POL_NONE));

endmodule

// File: tb/syn_update_ctrl_test.sv
module syn_update_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int WIN  = 8;
   localparam int UNIT = 3;
   localparam int MULT = 3;
   localparam int WW   = 2;
   localparam int WINIT = 1;
   localparam int WMAX = (1 << WW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic pre = 1'b0;
   logic post = 1'b0;
   logic abort_in = 1'b0;
   logic ltp, ltd, inc, dec, path_en;
   logic [1:0] pol;
   logic [WW-1:0] weight;

   always #(CLK_PERIOD/2) clk = ~clk;

   syn_update_ctrl #(
      .WIN_TICKS(WIN), .UNIT_TICKS(UNIT), .SET_MULT(MULT),
      .WEIGHT_W(WW), .WEIGHT_INIT(WINIT), .EDGE_DETECT(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .pre_spk_i(pre),
      .post_spk_i(post), .upd_abort_i(abort_in), .ltp_en_o(ltp),
      .ltd_en_o(ltd), .drive_pol_o(pol), .wt_inc_o(inc), .wt_dec_o(dec),
      .weight_o(weight), .path_en_o(path_en)
   );

   typedef struct { int kind; int len; int w; } exp_t;  // kind: 0 inc, 1 dec, 2 abort
   exp_t exp_q[$];

   int checks = 0;
   int errors = 0;
   int wmodel = WINIT;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic push(input int kind);
      exp_t it;
      if (kind == 0 && wmodel < WMAX) wmodel++;
      if (kind == 1 && wmodel > 0) wmodel--;
      it.kind = kind;
      it.len  = (kind == 0) ? MULT*UNIT : (kind == 1 ? UNIT : 0);
      it.w    = wmodel;
      exp_q.push_back(it);
   endtask

   // Monitor / scoreboard
   int  act_cnt = 0;
   bit  prev_act = 0;
   bit  pend = 0;
   int  pend_w = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         bit act;
         bit fell;
         if (pend) begin
            chk(weight == pend_w[WW-1:0], "R8 weight", int'(weight), pend_w);
            pend = 0;
         end
         act = ltp | ltd;
         fell = !act && prev_act;
         if (act) begin
            act_cnt++;
            chk(!(ltp && ltd), "R5 exclusive", int'({ltp, ltd}), 2);
            chk(path_en == 1'b0, "R7 path cut", int'(path_en), 0);
            chk(pol == (ltp ? 2'b01 : 2'b11), "R2/R3 polarity", int'(pol), ltp ? 1 : 3);
         end
         if (fell) begin
            int kind;
            kind = inc ? 0 : (dec ? 1 : 2);
            chk(path_en == 1'b1, "R7 path restored", int'(path_en), 1);
            if (exp_q.size() == 0) begin
               chk(0, "R5 unexpected update", kind, -1);
            end else begin
               exp_t it;
               it = exp_q.pop_front();
               chk(kind == it.kind, "R8/R9 end kind", kind, it.kind);
               if (it.kind != 2) chk(act_cnt == it.len, "R6 pulse length", act_cnt, it.len);
               pend = 1;
               pend_w = it.w;
            end
            act_cnt = 0;
         end else if (inc || dec) begin
            chk(0, "R8 stray strobe", int'({inc, dec}), 0);
         end
         prev_act = act;
      end
   end

   task automatic idle_wait();
      @(negedge clk);
      while (ltp || ltd) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic pair(input int j);
      pre = 1'b1;
      @(negedge clk);
      pre = 1'b0;
      repeat (j - 1) @(negedge clk);
      post = 1'b1;
      @(negedge clk);
      post = 1'b0;
   endtask

   task automatic post_only();
      post = 1'b1;
      @(negedge clk);
      post = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs while in reset
      chk(!ltp && !ltd, "R1 enables", int'({ltp, ltd}), 0);
      chk(path_en == 1'b1, "R1 path", int'(path_en), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pol == 2'b00, "R1 polarity", int'(pol), 0);
      chk(weight == WINIT, "R1 weight", int'(weight), WINIT);
      chk(!inc && !dec, "R1 strobes", int'({inc, dec}), 0);

      // R2: post right after pre, and at the window edge
      push(0); pair(1); idle_wait();
      push(0); pair(WIN); idle_wait();
      // R3: post one tick past the window
      push(1); pair(WIN + 1); idle_wait();
      // R3: post before pre; the later pre's window expires unused
      push(1); post_only(); idle_wait();
      pre = 1'b1; @(negedge clk); pre = 1'b0;
      repeat (WIN + 2) @(negedge clk);
      // R4: second pre restarts the window
      pre = 1'b1; @(negedge clk); pre = 1'b0;
      repeat (5) @(negedge clk);
      push(0); pair(WIN); idle_wait();
      // R12: window consumed by the potentiation
      push(1); post_only(); idle_wait();
      // R5: spikes during an update are ignored
      push(1); post_only();
      pre = 1'b1; post = 1'b1; @(negedge clk);
      pre = 1'b0; post = 1'b0;
      idle_wait();
      push(1); post_only(); idle_wait();   // R8 low saturation
      // R8: upper saturation
      for (int k = 0; k < WMAX + 1; k++) begin
         push(0); pair(1); idle_wait();
      end
      // R9: abort a depression
      push(2); post_only();
      abort_in = 1'b1; @(negedge clk); abort_in = 1'b0;
      chk(!ltd, "R9 aborted", int'(ltd), 0);
      chk(!dec, "R9 no strobe", int'(dec), 0);
      idle_wait();
      // R10: no ticks, window holds
      tick = 1'b0;
      pre = 1'b1; @(negedge clk); pre = 1'b0;
      repeat (3*WIN) @(negedge clk);
      tick = 1'b1;
      push(0); post_only(); idle_wait();
      // R11: pre held high counts once; window expires
      pre = 1'b1;
      repeat (WIN + 3) @(negedge clk);
      pre = 1'b0;
      push(1); post_only(); idle_wait();
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5/R8 scoreboard drained", exp_q.size(), 0);
      chk(weight == wmodel[WW-1:0], "R8 final weight", int'(weight), wmodel);
      finish_run();
   end

endmodule